// File: doc/BRIEF.md
# Carry-Select Adder with Increment-Derived Alternatives

This block adds two 16-bit words and a carry input and returns a 16-bit sum with a carry output. The same bits serve unsigned and two's-complement operands, because only the bit pattern of the result matters. It is purely combinational: the outputs follow the inputs with no clock and no state.

The word is split into five slices. From the least significant end upward they are 2, 2, 3, 4 and 5 bits wide. The lowest slice is a plain ripple adder fed by the external carry. Each higher slice has one ripple adder whose carry input is tied to zero. An incrementer takes that adder's sum, with its carry appended on top, and adds one to it. The result is the answer the slice would give with a carry input of one. A two-way selector in each slice picks between the two answers once the real carry from the slice below arrives. The carry chosen in one slice drives the selector of the next slice.

The incrementer flips output bit 0 unconditionally. It flips each higher bit when every input bit below it is one. It needs fewer gates than a second ripple adder.

Top module: `csel_bec_adder`

## Requirements
- R1: For all unsigned operands, {cout, sum} equals a + b + cin as a 17-bit value.
- R2: For two's-complement operands, sum carries the bit pattern of the signed sum modulo 2^16. Mixed-sign pairs and pairs of negative numbers are included.
- R3: Setting cin to 1 increases {cout, sum} by exactly one over the result with cin at 0, for the same a and b.
- R4: A carry generated in the top bit of any slice enters the next slice and alters its sum. The slice boundaries sit after bits 1, 3, 6 and 10.
- R5: 0x0000 + 0x0000 with cin 0 gives sum 0x0000 and cout 0.
- R6: 0xFFFF + 0x0001 with cin 0 gives sum 0x0000 and cout 1. The carry crosses every slice boundary.
- R7: 0xFFFF + 0xFFFF with cin 1 gives sum 0xFFFF and cout 1.
- R8: The outputs depend only on the present inputs. A result is valid one nanosecond after an input change, whatever the clock is doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The bench pushes a carry across each slice boundary one at a time. A selector wired to the wrong carry, or an incrementer whose top bit is not taken as the slice carry-out, would leave the next slice's sum unchanged. All-ones plus one ripples through every incrementer at once, so a converter that flips a bit on the wrong condition shows up as a nonzero sum. All-ones plus all-ones with carry in one checks that a full-width carry-in-1 path returns all ones with a carry out. Exhaustive sweeps of the low bits with both carry values cover the two narrow bottom slices completely, and random pairs check the rest of the word.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned NBLK = 5;
  localparam int unsigned BLK_W [NBLK] = '{2, 2, 3, 4, 5};

  // Bit index of the first bit of slice k (k == NBLK gives the total width)
  function automatic int unsigned blk_lo(input int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < NBLK; j++) begin
      if (j < k) acc += BLK_W[j];
    end
    return acc;
  endfunction

  localparam int unsigned DATA_W = blk_lo(NBLK);
endpackage

// File: rtl/rca_slice.sv
module rca_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign co = c[W];
endmodule

// File: rtl/excess_one_conv.sv
module excess_one_conv #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  assign dout[0] = ~din[0];
  for (genvar i = 1; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ (&din[i-1:0]);
  end
endmodule

// File: rtl/csel_slice.sv
module csel_slice #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_zero;
  logic         c_zero;
  logic [W:0]   inc_out;

  rca_slice #(.W(W)) u_rca (
    .a  (a),
    .b  (b),
    .ci (1'b0),
    .s  (s_zero),
    .co (c_zero)
  );

  excess_one_conv #(.W(W + 1)) u_inc (
    .din  ({c_zero, s_zero}),
    .dout (inc_out)
  );

  always_comb begin
    if (ci) {co, s} = inc_out;
    else    {co, s} = {c_zero, s_zero};
  end
endmodule

// File: rtl/csel_bec_adder.sv
module csel_bec_adder (
  input  logic [csel_pkg::DATA_W-1:0] a,
  input  logic [csel_pkg::DATA_W-1:0] b,
  input  logic                        cin,
  output logic [csel_pkg::DATA_W-1:0] sum,
  output logic                        cout
);
  localparam int unsigned NBLK = csel_pkg::NBLK;

  logic [NBLK:0] blk_cy;
  assign blk_cy[0] = cin;

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int unsigned LO = csel_pkg::blk_lo(k);
    localparam int unsigned BW = csel_pkg::BLK_W[k];
    if (k == 0) begin : g_base
      rca_slice #(.W(BW)) u_rca (
        .a  (a[LO +: BW]),
        .b  (b[LO +: BW]),
        .ci (blk_cy[k]),
        .s  (sum[LO +: BW]),
        .co (blk_cy[k+1])
      );
    end else begin : g_sel
      csel_slice #(.W(BW)) u_sel (
        .a  (a[LO +: BW]),
        .b  (b[LO +: BW]),
        .ci (blk_cy[k]),
        .s  (sum[LO +: BW]),
        .co (blk_cy[k+1])
      );
    end
  end

  assign cout = blk_cy[NBLK];
endmodule

// File: rtl/csel_bec_adder_chk.sv
module csel_bec_adder_chk (
  input logic [csel_pkg::DATA_W-1:0] a,
  input logic [csel_pkg::DATA_W-1:0] b,
  input logic                        cin,
  input logic [csel_pkg::DATA_W-1:0] sum,
  input logic                        cout,
  input logic [csel_pkg::NBLK:0]     blk_cy
);
  localparam int unsigned DW = csel_pkg::DATA_W;

  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_full_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin}))
        else $error("p_full_sum_r1");
      if (a == '0 && b == '0 && !cin) begin
        p_zero_r5: assert (sum == '0 && !cout) else $error("p_zero_r5");
      end
      if (a == '1 && b == '1 && cin) begin
        p_all_ones_r7: assert (sum == '1 && cout) else $error("p_all_ones_r7");
      end
    end
  end

  for (genvar k = 1; k < csel_pkg::NBLK; k++) begin : g_cy
    localparam int unsigned HI = csel_pkg::blk_lo(k);
    always_comb begin
      if (!$isunknown({a, b, cin})) begin
        p_slice_carry_r4: assert (blk_cy[k] ==
          ((({1'b0, a[HI-1:0]}) + ({1'b0, b[HI-1:0]}) + {{HI{1'b0}}, cin}) >> HI) != 0)
          else $error("p_slice_carry_r4");
      end
    end
  end
endmodule

bind csel_bec_adder csel_bec_adder_chk u_chk (
  .a      (a),
  .b      (b),
  .cin    (cin),
  .sum    (sum),
  .cout   (cout),
  .blk_cy (blk_cy)
);

// File: tb/csel_bec_adder_tb.sv
`timescale 1ns/1ps
module csel_bec_adder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  csel_bec_adder u_dut (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  task automatic apply_check(input logic [15:0] xa, input logic [15:0] xb,
                             input logic xc, input string req);
    logic [16:0] exp;
    a = xa; b = xb; cin = xc;
    #1;
    exp = {1'b0, xa} + {1'b0, xb} + {16'd0, xc};
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_err++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, xa, xb, xc, {cout, sum}, exp);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    n_chk++;
    if (sum !== 16'h0000 || cout !== 1'b0) begin
      n_err++;
      $display("FAIL R5 reset state got=%h exp=00000", {cout, sum});
    end
  endtask

  task automatic t_low_sweep;
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        for (int c = 0; c < 2; c++)
          apply_check(16'(i), 16'(j), c[0], "R1");
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++)
      apply_check(16'($urandom), 16'($urandom), 1'($urandom), "R1");
  endtask

  task automatic t_signed;
    apply_check(16'hFFFB, 16'h0003, 1'b0, "R2");
    apply_check(16'h8000, 16'hFFFF, 1'b0, "R2");
    apply_check(16'h7FFF, 16'h0001, 1'b0, "R2");
    apply_check(16'hFF9C, 16'hFF38, 1'b1, "R2");
  endtask

  task automatic t_cin_step;
    logic [16:0] r0;
    for (int n = 0; n < 50; n++) begin
      logic [15:0] xa, xb;
      xa = 16'($urandom); xb = 16'($urandom);
      a = xa; b = xb; cin = 1'b0; #1; r0 = {cout, sum};
      cin = 1'b1; #1;
      n_chk++;
      if ({cout, sum} !== r0 + 17'd1) begin
        n_err++;
        $display("FAIL R3 a=%h b=%h got=%h exp=%h", xa, xb, {cout, sum}, r0 + 17'd1);
      end
    end
  endtask

  task automatic t_boundaries;
    int bnd [4] = '{1, 3, 6, 10};
    foreach (bnd[k]) begin
      apply_check(16'(1) << bnd[k], 16'(1) << bnd[k], 1'b0, "R4");
      apply_check(16'(1) << bnd[k], 16'(1) << bnd[k], 1'b1, "R4");
      apply_check((16'(1) << (bnd[k] + 1)) - 16'd1, 16'd1, 1'b0, "R4");
    end
  endtask

  task automatic t_corners;
    apply_check(16'h0000, 16'h0000, 1'b0, "R5");
    apply_check(16'hFFFF, 16'h0001, 1'b0, "R6");
    apply_check(16'hFFFF, 16'hFFFF, 1'b1, "R7");
  endtask

  task automatic t_no_clock;
    // change inputs right after a rising edge, read before the next one
    @(posedge clk);
    apply_check(16'h1234, 16'h4321, 1'b1, "R8");
    apply_check(16'hA5A5, 16'h5A5A, 1'b0, "R8");
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset_state();
    rst = 1'b0;
    @(negedge clk);
    t_low_sweep();
    t_random();
    t_signed();
    t_cin_step();
    t_boundaries();
    t_corners();
    t_no_clock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule